// File: doc/BRIEF.md
# DMA Start Vector Dispatcher

The dispatcher sits between the interrupt controller and a small bank of DMA channels. Each channel holds a start-vector register. When the interrupt controller presents a pending vector, the dispatcher compares it with every channel's register. If a channel matches, the dispatcher sends that channel a transfer start. If no channel matches, the request is passed on as an ordinary CPU interrupt. A register value of zero marks a channel as unassigned, so it never matches.

When the transfer engine reports that a channel's count has reached zero, the dispatcher raises that channel's end-of-transfer interrupt. In the same clock edge it clears the channel's start vector to zero. To keep a channel serving its source, software writes the vector again while it handles the end interrupt. If several channels hold the same vector, the lowest-numbered one wins. Two channels loaded with one vector therefore chain: the lower channel serves until its count runs out, and the higher channel takes over from then on.

Top module: `dma_vec_dispatch`

## Requirements
- R1: After reset every start-vector register holds 0, and `dma_start`, `cpu_irq` and all `end_irq` bits are 0.
- R2: A cycle with `irq_valid`=1 and an `irq_vec` equal to a channel's nonzero register gives `dma_start`=1, `dma_ch`=that channel number and `cpu_irq`=0 in the following cycle.
- R3: A cycle with `irq_valid`=1 and no matching channel gives `cpu_irq`=1 and `dma_start`=0 in the following cycle.
- R4: A register holding 0 never matches, so `irq_vec`=0 always yields `cpu_irq`.
- R5: When several channels hold the requested vector, `dma_ch` is the lowest channel number among them.
- R6: `cnt_zero[i]`=1 in a cycle gives `end_irq[i]`=1 in the following cycle, one cycle per asserted cycle.
- R7: `cnt_zero[i]` clears channel i's register to 0 at that edge. Later requests with the old vector go to the next higher channel holding it, or to the CPU if none does.
- R8: A write (`wr_en`=1, `wr_ch`=i) in the same cycle as `cnt_zero[i]` takes precedence: the register takes `wr_data`.
- R9: A request presented in the same cycle as a write or a count-zero clear is matched against the register contents from before that edge.
- R10: A cycle with `irq_valid`=0 gives `dma_start`=0 and `cpu_irq`=0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_valid | input | 1 | Pending interrupt vector is presented |
| irq_vec | input | VEC_W (6) | Pending interrupt vector code |
| cnt_zero | input | NUM_CH (4) | Per-channel transfer count reached zero |
| wr_en | input | 1 | Start-vector register write strobe |
| wr_ch | input | CH_W (2) | Channel whose register is written |
| wr_data | input | VEC_W (6) | New start vector |
| dma_start | output | 1 | Transfer start strobe |
| dma_ch | output | CH_W (2) | Channel selected for the start |
| cpu_irq | output | 1 | Request forwarded as a CPU interrupt |
| end_irq | output | NUM_CH (4) | Per-channel end-of-transfer interrupt |

## Verification
A request, a count-zero clear and a register write can all land on the same channel in the same cycle. The bench provokes this in two ways. First, it presents a vector held by channel 0 together with `cnt_zero[0]`, and expects a start on channel 0, `end_irq[0]` one cycle later, and the next request with that vector handed to channel 1. Second, it drives a write and `cnt_zero` together on one channel, then sweeps all 64 vectors to confirm that the written value survived and the old one is gone. Every sweep compares the outputs against a bench-side model of the four registers.

// File: rtl/dmad_pkg.sv
// Shared types of the DMA start vector dispatcher.
// Assumes: nothing beyond IEEE 1800-2017.
package dmad_pkg;
    // Outcome of one vector lookup
    typedef enum logic [1:0] {
        OUT_NONE = 2'd0,
        OUT_DMA  = 2'd1,
        OUT_CPU  = 2'd2
    } dmad_outcome_e;
endpackage

// File: rtl/dmad_vec_regs.sv
// Bank of per-channel start-vector registers.
// A software write to a channel has precedence over that channel's count-zero clear.
// Assumes: wr_ch is below NUM_CH whenever wr_en is high.
module dmad_vec_regs #(
    parameter int NUM_CH = 4,
    parameter int VEC_W  = 6,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [CH_W-1:0]         wr_ch,
    input  logic [VEC_W-1:0]        wr_data,
    input  logic [NUM_CH-1:0]       cnt_zero,
    output logic [NUM_CH*VEC_W-1:0] vec_flat
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [VEC_W-1:0] vec_q;
        logic             sel;

        // Decode a write aimed at this channel
        assign sel = wr_en && (wr_ch == CH_W'(g));

        // Hold the start vector: write first, then the clear, else keep
        always_ff @(posedge clk) begin
            if (!rst_n)
                vec_q <= '0;
            else if (sel)
                vec_q <= wr_data;
            else if (cnt_zero[g])
                vec_q <= '0;
        end

        assign vec_flat[g*VEC_W +: VEC_W] = vec_q;
    end
endmodule

// File: rtl/dmad_match.sv
// Combinational lookup: compares the pending vector with every channel register
// and picks the lowest-numbered nonzero match.
// Assumes: vec_flat holds register contents from before the current edge.
module dmad_match
    import dmad_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int VEC_W  = 6,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    irq_valid,
    input  logic [VEC_W-1:0]        irq_vec,
    input  logic [NUM_CH*VEC_W-1:0] vec_flat,
    output dmad_outcome_e           outcome,
    output logic [CH_W-1:0]         hit_ch
);
    logic [NUM_CH-1:0] hit;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
        // A zero register is unassigned and never matches
        assign hit[g] = (vec_flat[g*VEC_W +: VEC_W] != '0) &&
                        (vec_flat[g*VEC_W +: VEC_W] == irq_vec);
    end

    // Priority pick: scan downward so the lowest channel wins
    always_comb begin
        hit_ch = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (hit[i]) hit_ch = CH_W'(i);
        end
    end

    // Classify the request
    always_comb begin
        if (!irq_valid)
            outcome = OUT_NONE;
        else if (hit != '0)
            outcome = OUT_DMA;
        else
            outcome = OUT_CPU;
    end
endmodule

// File: rtl/dmad_out.sv
// Output stage: registers the lookup outcome and the end-of-transfer interrupts.
// Assumes: outcome and hit_ch are settled before the clock edge.
module dmad_out
    import dmad_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dmad_outcome_e     outcome,
    input  logic [CH_W-1:0]   hit_ch,
    input  logic [NUM_CH-1:0] cnt_zero,
    output logic              dma_start,
    output logic [CH_W-1:0]   dma_ch,
    output logic              cpu_irq,
    output logic [NUM_CH-1:0] end_irq
);
    // Register the dispatch strobes and the selected channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_start <= 1'b0;
            cpu_irq   <= 1'b0;
            dma_ch    <= '0;
        end else begin
            dma_start <= (outcome == OUT_DMA);
            cpu_irq   <= (outcome == OUT_CPU);
            if (outcome == OUT_DMA) dma_ch <= hit_ch;
        end
    end

    // Register the per-channel end-of-transfer interrupts
    always_ff @(posedge clk) begin
        if (!rst_n) end_irq <= '0;
        else        end_irq <= cnt_zero;
    end
endmodule

// File: rtl/dma_vec_dispatch.sv
// Top of the DMA start vector dispatcher: register bank, lookup and output stage.
// Assumes: synchronous active-low reset; one pending vector per cycle.
module dma_vec_dispatch
    import dmad_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int VEC_W  = 6,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_valid,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic [NUM_CH-1:0] cnt_zero,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [VEC_W-1:0]  wr_data,
    output logic              dma_start,
    output logic [CH_W-1:0]   dma_ch,
    output logic              cpu_irq,
    output logic [NUM_CH-1:0] end_irq
);
    logic [NUM_CH*VEC_W-1:0] vec_flat;
    dmad_outcome_e           outcome;
    logic [CH_W-1:0]         hit_ch;

    dmad_vec_regs #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ch    (wr_ch),
        .wr_data  (wr_data),
        .cnt_zero (cnt_zero),
        .vec_flat (vec_flat)
    );

    dmad_match #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) u_match (
        .irq_valid (irq_valid),
        .irq_vec   (irq_vec),
        .vec_flat  (vec_flat),
        .outcome   (outcome),
        .hit_ch    (hit_ch)
    );

    dmad_out #(.NUM_CH(NUM_CH)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .outcome   (outcome),
        .hit_ch    (hit_ch),
        .cnt_zero  (cnt_zero),
        .dma_start (dma_start),
        .dma_ch    (dma_ch),
        .cpu_irq   (cpu_irq),
        .end_irq   (end_irq)
    );
endmodule

// File: rtl/dmad_checker.sv
// Property checker for the dispatcher, bound to the top module.
// Assumes: same parameters as the top; observes the register bank through vec_flat.
module dmad_checker #(
    parameter int NUM_CH = 4,
    parameter int VEC_W  = 6,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    irq_valid,
    input logic [NUM_CH-1:0]       cnt_zero,
    input logic                    wr_en,
    input logic [CH_W-1:0]         wr_ch,
    input logic [VEC_W-1:0]        wr_data,
    input logic                    dma_start,
    input logic                    cpu_irq,
    input logic [NUM_CH-1:0]       end_irq,
    input logic [NUM_CH*VEC_W-1:0] vec_flat
);
    p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_start && cpu_irq));

    p_valid_answered_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> (dma_start || cpu_irq));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |=> (!dma_start && !cpu_irq));

    p_end_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_zero != '0) |=> (end_irq == $past(cnt_zero)));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_zero[g] && !(wr_en && wr_ch == CH_W'(g)))
            |=> (vec_flat[g*VEC_W +: VEC_W] == '0));

        p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_ch == CH_W'(g))
            |=> (vec_flat[g*VEC_W +: VEC_W] == $past(wr_data)));
    end
endmodule

bind dma_vec_dispatch dmad_checker #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_valid (irq_valid),
    .cnt_zero  (cnt_zero),
    .wr_en     (wr_en),
    .wr_ch     (wr_ch),
    .wr_data   (wr_data),
    .dma_start (dma_start),
    .cpu_irq   (cpu_irq),
    .end_irq   (end_irq),
    .vec_flat  (vec_flat)
);

// File: tb/sim_dma_vec_dispatch.sv
// Self-checking bench: full sweeps of all vectors against a model of four registers.
module sim_dma_vec_dispatch;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int VW  = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           irq_valid = 1'b0;
    logic [VW-1:0]  irq_vec = '0;
    logic [NCH-1:0] cnt_zero = '0;
    logic           wr_en = 1'b0;
    logic [1:0]     wr_ch = '0;
    logic [VW-1:0]  wr_data = '0;
    logic           dma_start;
    logic [1:0]     dma_ch;
    logic           cpu_irq;
    logic [NCH-1:0] end_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [VW-1:0] mdl [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_vec_dispatch #(.NUM_CH(NCH), .VEC_W(VW)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_vec(irq_vec),
        .cnt_zero(cnt_zero), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
        .dma_start(dma_start), .dma_ch(dma_ch), .cpu_irq(cpu_irq), .end_irq(end_irq)
    );

    // Compare all outputs with expectations
    task automatic check(string tag, bit e_start, logic [1:0] e_ch, bit e_cpu, logic [NCH-1:0] e_end);
        n_chk++;
        if (dma_start !== e_start || cpu_irq !== e_cpu || end_irq !== e_end ||
            (e_start && dma_ch !== e_ch)) begin
            n_bad++;
            $display("FAIL %s: start=%0b ch=%0d cpu=%0b end=%b expected start=%0b ch=%0d cpu=%0b end=%b",
                     tag, dma_start, dma_ch, cpu_irq, end_irq, e_start, e_ch, e_cpu, e_end);
        end
    endtask

    // One clock step: inputs were set after a falling edge, sample at the next one
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(int ch, int v);
        wr_en = 1'b1; wr_ch = 2'(ch); wr_data = VW'(v);
        step();
        wr_en = 1'b0;
        mdl[ch] = VW'(v);
    endtask

    // Expected channel for a vector: lowest channel with a nonzero equal entry, else -1
    function automatic int pick(int v);
        for (int i = 0; i < NCH; i++)
            if (v != 0 && int'(mdl[i]) == v) return i;
        return -1;
    endfunction

    task automatic req(string tag, int v);
        int e;
        e = pick(v);
        irq_valid = 1'b1; irq_vec = VW'(v);
        step();
        irq_valid = 1'b0;
        check(tag, e >= 0, 2'(e < 0 ? 0 : e), e < 0, '0);
    endtask

    task automatic sweep(string tag);
        for (int v = 0; v < (1 << VW); v++) req(tag, v);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NCH; i++) mdl[i] = '0;
        @(negedge clk); @(negedge clk);
        check("R1 reset outputs", 0, 0, 0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1, R4: empty registers, every vector goes to the CPU
        sweep("R1 R4 empty bank");
        step();
        check("R10 idle", 0, 0, 0, '0);

        // R2, R5: duplicates resolved by lowest channel
        wr(0, 5); wr(1, 5); wr(2, 9); wr(3, 63);
        sweep("R2 R3 R5 loaded bank");
        req("R5 duplicate 5 to ch0", 5);

        // R6, R7: count zero on ch0 ends it and hands vector 5 to ch1
        cnt_zero = 4'b0001;
        step();
        cnt_zero = '0;
        mdl[0] = '0;
        check("R6 end irq ch0", 0, 0, 0, 4'b0001);
        req("R7 chain to ch1", 5);
        sweep("R7 after clear");

        // Re-arm ch0 by rewriting its vector
        wr(0, 5);
        req("R7 rearm ch0", 5);

        // R9: request and clear on ch0 in the same cycle use the old contents
        irq_valid = 1'b1; irq_vec = VW'(5); cnt_zero = 4'b0001;
        step();
        irq_valid = 1'b0; cnt_zero = '0; mdl[0] = '0;
        check("R9 R6 same-cycle clear", 1, 2'd0, 0, 4'b0001);
        req("R7 next goes to ch1", 5);

        // R8: write wins over clear on ch2
        wr_en = 1'b1; wr_ch = 2'd2; wr_data = VW'(12); cnt_zero = 4'b0100;
        step();
        wr_en = 1'b0; cnt_zero = '0; mdl[2] = VW'(12);
        check("R8 end irq ch2", 0, 0, 0, 4'b0100);
        req("R8 new vector kept", 12);
        req("R8 old vector gone", 9);

        // R9: request in the same cycle as a write sees the old value
        irq_valid = 1'b1; irq_vec = VW'(40); wr_en = 1'b1; wr_ch = 2'd3; wr_data = VW'(40);
        step();
        irq_valid = 1'b0; wr_en = 1'b0; mdl[3] = VW'(40);
        check("R9 same-cycle write", 0, 0, 1, '0);
        req("R9 write visible next", 40);

        // R6: multiple simultaneous ends, held two cycles
        cnt_zero = 4'b1010;
        step();
        check("R6 two ends cycle1", 0, 0, 0, 4'b1010);
        step();
        cnt_zero = '0; mdl[1] = '0; mdl[3] = '0;
        check("R6 two ends cycle2", 0, 0, 0, 4'b1010);
        step();
        check("R6 ends drop", 0, 0, 0, '0);
        sweep("R7 R3 final bank");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule